// File: doc/BRIEF.md
# Multichannel Parallel IQ Output Port

The block collects processed samples from up to eight gain-control channels and moves them, one word per port clock, onto a single 16-bit parallel bus. Each sample arrives as an 8-bit I value, an 8-bit Q value and a 12-bit gain value with a one-cycle valid strobe. A one-entry holding register per channel keeps the sample until it is sent. The port tells the downstream processor that data is waiting with a request line. It places words on the bus only while the processor's acknowledge is high.

Each bus word carries a 3-bit tag that names its source channel. An IQ flag marks cycles that carry a sample word. When gain output is enabled, every sample word is followed by a gain word, and a separate gain flag marks that word. Pending channels are served lowest number first. A strobe that arrives while an older sample is still unsent replaces it and sets a sticky per-channel overflow flag.

Top module: `iqport_top`

## Requirements
- R1: A sample word places I on bus bits 15:8 and Q on bus bits 7:0, and the IQ flag is 1 in that cycle.
- R2: The channel output carries the 3-bit binary number of the channel whose sample or gain is on the bus.
- R3: `req` is 1 from the cycle after a valid strobe. A word appears on the bus only in the cycle after `ack` was sampled 1 at a clock edge.
- R4: While `ack` stays 1, one word is sent per cycle. Pending channels go out in ascending channel order, and the IQ flag stays 1 across consecutive sample words.
- R5: When `gain_en` is 1 at the edge that sends a sample word, the next word sent is a gain word. It carries bits 15:12 = 0 and bits 11:0 = the channel's gain, with the gain flag at 1 and the IQ flag at 0.
- R6: `req` falls to 0 in the cycle in which the last owed word is on the bus.
- R7: When `ack` is 0 at an edge, no word is sent in the following cycle, the bus is idle, and `req` stays 1 while work is still owed.
- R8: A strobe on a channel that already holds an unsent sample replaces that sample and sets the channel's bit in `ovf_flag`. The bit stays set until reset.
- R9: In an idle cycle, the data and channel outputs and both flags are 0. Synchronous active-high `rst` clears all pending samples, the overflow flags, `req` and the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 8 | Per-channel sample valid strobes |
| smp_i | input | 64 | I values, channel c at bits 8c+7:8c |
| smp_q | input | 64 | Q values, channel c at bits 8c+7:8c |
| smp_gain | input | 96 | Gain values, channel c at bits 12c+11:12c |
| gain_en | input | 1 | Send a gain word after each sample word |
| ack | input | 1 | Receiver ready |
| req | output | 1 | Data waiting |
| bus_data | output | 16 | Parallel data word |
| bus_ch | output | 3 | Source channel of the current word |
| bus_iq | output | 1 | Sample word marker |
| bus_gain | output | 1 | Gain word marker |
| ovf_flag | output | 8 | Sticky per-channel overwrite flags |

## Verification
The assertions assume that `ack` is a clean synchronous level. They also assume that `smp_vld` and `gain_en` change only between clock edges and never carry unknown values after reset. The bench drives every input shortly after a rising edge and samples the outputs two time units after the next edge, so each input is stable across the edge that captures it. Overflow is provoked only by two strobes on one channel while `ack` is held at 0, which keeps the replaced value observable on the bus afterwards.

// File: rtl/iqport_pkg.sv
package iqport_pkg;
    typedef enum logic {
        PH_IQ   = 1'b0,
        PH_GAIN = 1'b1
    } phase_t;
endpackage

// File: rtl/iqport_hold.sv
module iqport_hold #(
    parameter int NUM_CH = 8,
    parameter int IQ_W   = 8,
    parameter int GAIN_W = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_CH-1:0]        vld,
    input  logic [NUM_CH*IQ_W-1:0]   din_i,
    input  logic [NUM_CH*IQ_W-1:0]   din_q,
    input  logic [NUM_CH*GAIN_W-1:0] din_g,
    input  logic [NUM_CH-1:0]        take,
    output logic [NUM_CH-1:0]        pend,
    output logic [NUM_CH-1:0]        ovf,
    output logic [NUM_CH*IQ_W-1:0]   hold_i,
    output logic [NUM_CH*IQ_W-1:0]   hold_q,
    output logic [NUM_CH*GAIN_W-1:0] hold_g
);
    typedef struct packed {
        logic              pend;
        logic              ovf;
        logic [IQ_W-1:0]   i;
        logic [IQ_W-1:0]   q;
        logic [GAIN_W-1:0] g;
    } slot_t;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_slot
        slot_t slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (take[c]) slot_d.pend = 1'b0;
            if (vld[c]) begin
                slot_d.pend = 1'b1;
                slot_d.i    = din_i[c*IQ_W +: IQ_W];
                slot_d.q    = din_q[c*IQ_W +: IQ_W];
                slot_d.g    = din_g[c*GAIN_W +: GAIN_W];
                if (slot_q.pend && !take[c]) slot_d.ovf = 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) slot_q <= '0;
            else     slot_q <= slot_d;
        end

        assign pend[c]                   = slot_q.pend;
        assign ovf[c]                    = slot_q.ovf;
        assign hold_i[c*IQ_W +: IQ_W]     = slot_q.i;
        assign hold_q[c*IQ_W +: IQ_W]     = slot_q.q;
        assign hold_g[c*GAIN_W +: GAIN_W] = slot_q.g;

        a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
            slot_q.ovf |=> slot_q.ovf);
        a_r3_strobe_pends: assert property (@(posedge clk) disable iff (rst)
            vld[c] |=> slot_q.pend);
    end
endmodule

// File: rtl/iqport_pick.sv
module iqport_pick #(
    parameter int NUM_CH = 8,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0] pend,
    output logic [NUM_CH-1:0] gnt,
    output logic [CH_W-1:0]   idx,
    output logic              any
);
    always_comb begin
        idx = '0;
        any = |pend;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (pend[c]) idx = CH_W'(c);
        end
        gnt = any ? (NUM_CH'(1) << idx) : '0;
    end
endmodule

// File: rtl/iqport_top.sv
module iqport_top
    import iqport_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int IQ_W   = 8,
    parameter int GAIN_W = 12,
    localparam int BUS_W = 2 * IQ_W,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_CH-1:0]        smp_vld,
    input  logic [NUM_CH*IQ_W-1:0]   smp_i,
    input  logic [NUM_CH*IQ_W-1:0]   smp_q,
    input  logic [NUM_CH*GAIN_W-1:0] smp_gain,
    input  logic                     gain_en,
    input  logic                     ack,
    output logic                     req,
    output logic [BUS_W-1:0]         bus_data,
    output logic [CH_W-1:0]          bus_ch,
    output logic                     bus_iq,
    output logic                     bus_gain,
    output logic [NUM_CH-1:0]        ovf_flag
);
    typedef struct packed {
        phase_t            phase;
        logic [BUS_W-1:0]  data;
        logic [CH_W-1:0]   ch;
        logic              iq;
        logic              gain;
        logic [CH_W-1:0]   gch;
        logic [GAIN_W-1:0] gval;
    } st_t;

    st_t st_d, st_q;

    logic [NUM_CH-1:0]        take, pend, gnt;
    logic [NUM_CH*IQ_W-1:0]   hold_i, hold_q;
    logic [NUM_CH*GAIN_W-1:0] hold_g;
    logic [CH_W-1:0]          idx;
    logic                     any;

    iqport_hold #(.NUM_CH(NUM_CH), .IQ_W(IQ_W), .GAIN_W(GAIN_W)) u_hold (
        .clk(clk), .rst(rst), .vld(smp_vld),
        .din_i(smp_i), .din_q(smp_q), .din_g(smp_gain),
        .take(take), .pend(pend), .ovf(ovf_flag),
        .hold_i(hold_i), .hold_q(hold_q), .hold_g(hold_g)
    );

    iqport_pick #(.NUM_CH(NUM_CH)) u_pick (
        .pend(pend), .gnt(gnt), .idx(idx), .any(any)
    );

    always_comb begin
        st_d      = st_q;
        st_d.data = '0;
        st_d.ch   = '0;
        st_d.iq   = 1'b0;
        st_d.gain = 1'b0;
        take      = '0;
        if (ack) begin
            if (st_q.phase == PH_GAIN) begin
                st_d.data  = {{(BUS_W-GAIN_W){1'b0}}, st_q.gval};
                st_d.ch    = st_q.gch;
                st_d.gain  = 1'b1;
                st_d.phase = PH_IQ;
            end else if (any) begin
                st_d.data = {hold_i[idx*IQ_W +: IQ_W], hold_q[idx*IQ_W +: IQ_W]};
                st_d.ch   = idx;
                st_d.iq   = 1'b1;
                take      = gnt;
                if (gain_en) begin
                    st_d.phase = PH_GAIN;
                    st_d.gch   = idx;
                    st_d.gval  = hold_g[idx*GAIN_W +: GAIN_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign req      = any || (st_q.phase == PH_GAIN);
    assign bus_data = st_q.data;
    assign bus_ch   = st_q.ch;
    assign bus_iq   = st_q.iq;
    assign bus_gain = st_q.gain;

    a_r3_word_after_ack: assert property (@(posedge clk) disable iff (rst)
        (bus_iq || bus_gain) |-> $past(ack));
    a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(bus_iq && bus_gain));
    a_r5_gain_upper_zero: assert property (@(posedge clk) disable iff (rst)
        bus_gain |-> (bus_data[BUS_W-1:GAIN_W] == '0));
    a_r7_req_held: assert property (@(posedge clk) disable iff (rst)
        (req && !ack) |=> req);
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !(bus_iq || bus_gain) |-> (bus_data == '0 && bus_ch == '0));
    a_r4_take_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(take));
endmodule

// File: tb/iqport_top_tb.sv
module iqport_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  smp_vld = '0;
    logic [63:0] smp_i, smp_q;
    logic [95:0] smp_gain;
    logic        gain_en = 1'b0;
    logic        ack = 1'b0;
    logic        req, bus_iq, bus_gain;
    logic [15:0] bus_data;
    logic [2:0]  bus_ch;
    logic [7:0]  ovf_flag;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    iqport_top u_dut (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_i(smp_i), .smp_q(smp_q),
        .smp_gain(smp_gain), .gain_en(gain_en), .ack(ack), .req(req),
        .bus_data(bus_data), .bus_ch(bus_ch), .bus_iq(bus_iq),
        .bus_gain(bus_gain), .ovf_flag(ovf_flag)
    );

    typedef struct packed {
        logic [7:0]  vld;
        logic        ack;
        logic        gen;
        logic [15:0] data;
        logic [2:0]  ch;
        logic        iq;
        logic        gain;
        logic        req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [0:NV-1] = '{
        '{vld:8'h05, ack:0, gen:0, data:16'h0000, ch:0, iq:0, gain:0, req:1}, // R3
        '{vld:8'h00, ack:1, gen:0, data:16'hA050, ch:0, iq:1, gain:0, req:1}, // R1 R4
        '{vld:8'h00, ack:1, gen:0, data:16'hA252, ch:2, iq:1, gain:0, req:0}, // R4 R6
        '{vld:8'h00, ack:1, gen:0, data:16'h0000, ch:0, iq:0, gain:0, req:0}, // R9
        '{vld:8'h80, ack:0, gen:1, data:16'h0000, ch:0, iq:0, gain:0, req:1}, // R3
        '{vld:8'h00, ack:1, gen:1, data:16'hA757, ch:7, iq:1, gain:0, req:1}, // R2 R5
        '{vld:8'h00, ack:1, gen:1, data:16'h0307, ch:7, iq:0, gain:1, req:0}, // R5 R6
        '{vld:8'h02, ack:0, gen:1, data:16'h0000, ch:0, iq:0, gain:0, req:1}, // R3
        '{vld:8'h00, ack:1, gen:1, data:16'hA151, ch:1, iq:1, gain:0, req:1}, // R5
        '{vld:8'h00, ack:0, gen:1, data:16'h0000, ch:0, iq:0, gain:0, req:1}, // R7
        '{vld:8'h00, ack:1, gen:1, data:16'h0301, ch:1, iq:0, gain:1, req:0}, // R5
        '{vld:8'h18, ack:1, gen:0, data:16'h0000, ch:0, iq:0, gain:0, req:1}, // R3
        '{vld:8'h00, ack:1, gen:0, data:16'hA353, ch:3, iq:1, gain:0, req:1}, // R4
        '{vld:8'h00, ack:0, gen:0, data:16'h0000, ch:0, iq:0, gain:0, req:1}, // R7
        '{vld:8'h00, ack:1, gen:0, data:16'hA454, ch:4, iq:1, gain:0, req:0}  // R2 R6
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic load_data();
        for (int c = 0; c < 8; c++) begin
            smp_i[c*8 +: 8]     = 8'hA0 | 8'(c);
            smp_q[c*8 +: 8]     = 8'h50 | 8'(c);
            smp_gain[c*12 +: 12] = 12'h300 | 12'(c);
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        load_data();
        repeat (3) step();
        chk("R9 reset req", 32'(req), 0);
        chk("R9 reset bus", {bus_data, 5'(bus_ch), bus_iq, bus_gain}, 0);
        chk("R9 reset ovf", 32'(ovf_flag), 0);
        rst = 1'b0;
        step();

        for (int n = 0; n < NV; n++) begin
            smp_vld = VEC[n].vld;
            ack     = VEC[n].ack;
            gain_en = VEC[n].gen;
            step();
            chk($sformatf("R1 R5 data row %0d", n), 32'(bus_data), 32'(VEC[n].data));
            chk($sformatf("R2 ch row %0d", n), 32'(bus_ch), 32'(VEC[n].ch));
            chk($sformatf("R4 iq row %0d", n), 32'(bus_iq), 32'(VEC[n].iq));
            chk($sformatf("R5 gain row %0d", n), 32'(bus_gain), 32'(VEC[n].gain));
            chk($sformatf("R6 R7 req row %0d", n), 32'(req), 32'(VEC[n].req));
        end
        smp_vld = '0;
        ack = 1'b0;
        gain_en = 1'b0;
        chk("R8 no ovf so far", 32'(ovf_flag), 0);

        // R8: overwrite of an unsent sample on channel 5
        smp_vld = 8'h20;
        step();
        smp_i[40 +: 8] = 8'hEE;
        smp_q[40 +: 8] = 8'hDD;
        step();
        smp_vld = '0;
        chk("R8 ovf set", 32'(ovf_flag), 32'h20);
        chk("R7 req while waiting", 32'(req), 1);
        ack = 1'b1;
        step();
        chk("R8 newer sample sent", 32'(bus_data), 32'hEEDD);
        chk("R8 channel tag", 32'(bus_ch), 5);
        step();
        chk("R8 ovf sticky", 32'(ovf_flag), 32'h20);
        chk("R9 idle bus", {bus_data, 5'(bus_ch), bus_iq, bus_gain}, 0);
        ack = 1'b0;

        // R9: reset with a sample pending
        smp_vld = 8'h01;
        step();
        smp_vld = '0;
        chk("R3 pending before reset", 32'(req), 1);
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk("R9 reset drops req", 32'(req), 0);
        chk("R9 reset clears ovf", 32'(ovf_flag), 0);
        ack = 1'b1;
        step();
        chk("R9 nothing sent after reset", 32'(bus_iq), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule